// File: doc/BRIEF.md
# Single-to-Half Precision Float Narrowing Converter

This block converts a 32-bit IEEE-754 single-precision operand into a 16-bit half-precision result. Every operation carries its own 2-bit rounding-mode code, so neighbouring operations in the pipeline may use different modes. The block accepts one new operand on any cycle in which the input strobe is high. It returns the packed half-precision word, together with an inexact indication, a fixed two cycles later.

Special encodings pass through with their sign kept: NaNs are made quiet, and infinities and zeros are copied. Values too large or too small for the half format saturate or flush, and the value chosen depends on the rounding direction and the sign. Operands below the normal half range become subnormals through a variable right shift, with guard and sticky rounding. A rounding carry out of the fraction moves up into the exponent. Single-precision subnormal operands are treated as far underflow and are not normalised first.

Top module: `f32_to_f16_conv`

## Requirements
- R1: `out_valid` rises exactly two rising clock edges after an edge on which `in_valid` was sampled high, and is low otherwise. A synchronous active-high `rst` clears both pipeline valid stages, so an operation that is in flight at reset never appears.
- R2: An operand with exponent field 0xFF and a nonzero fraction gives a NaN. The sign is kept, the exponent field is 5'h1F, the result fraction is {1'b1, operand[21:13]}, and inexact is 0.
- R3: Exponent field 0xFF with a zero fraction gives {sign, 15'h7C00}. An all-zero exponent and fraction gives {sign, 15'h0000}. Inexact is 0 in both cases.
- R4: An exponent field of 143 or more overflows and sets inexact to 1. Mode 1 gives {sign, 15'h7BFF}. Mode 2 with a negative sign gives 16'hFBFF. Mode 3 with a positive sign gives 16'h7BFF. All other cases give {sign, 15'h7C00}.
- R5: An exponent field of 101 or less underflows and sets inexact to 1. This includes nonzero operands with a zero exponent field. Mode 2 with a positive sign gives 16'h0001. Mode 3 with a negative sign gives 16'h8001. All other cases give {sign, 15'h0000}.
- R6: For exponent fields 113 to 142, the pre-rounding result has exponent field (field − 112) and fraction operand[22:13].
- R7: For exponent fields 102 to 112, the result has exponent field 0. Its pre-rounding fraction is (2^23 + operand[22:0]) shifted right by (126 − field), and the bits shifted out become the discarded part.
- R8: Mode 0 (nearest-even) adds one when the discarded part is above half an LSB. At exactly half an LSB it adds one only when the kept LSB is 1.
- R9: Mode 1 (toward zero) never adds. Mode 2 (toward +inf) adds for positive operands with any discarded bit set. Mode 3 (toward −inf) adds for negative operands with any discarded bit set.
- R10: A rounding carry out of the 10-bit fraction clears the fraction and raises the exponent field by one. The largest subnormal becomes 16'h0400, and the largest finite value becomes infinity.
- R11: On the rounding path, inexact is 1 exactly when the discarded bits are nonzero. An exact result comes out unchanged with inexact 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand strobe |
| in_operand | input | 32 | Single-precision operand |
| in_mode | input | 2 | Rounding mode: 0 nearest-even, 1 toward zero, 2 toward +inf, 3 toward −inf |
| out_valid | output | 1 | Result strobe |
| out_result | output | 16 | Half-precision result |
| out_inexact | output | 1 | Result differs from the operand's exact value |

## Verification
Every result, special or rounded, comes out exactly two rising edges after the edge that captured its operand. The bench drives inputs on a falling edge and reads `out_valid`, `out_result` and `out_inexact` on the falling edge that follows the second rising edge. The vector table is applied one operation at a time in that pattern. A streaming test then issues three operations on back-to-back cycles and expects each result on the matching later falling edge, with `out_valid` low one cycle after the last. A reset test puts one operation in flight, asserts reset before its second edge, and checks that the result strobe never rises.

// File: rtl/f2h_pkg.sv
package f2h_pkg;

    localparam int SP_W       = 32;
    localparam int SP_EXP_W   = 8;
    localparam int SP_FRAC_W  = 23;
    localparam int SP_BIAS    = 127;
    localparam int HP_W       = 16;
    localparam int HP_EXP_W   = 5;
    localparam int HP_FRAC_W  = 10;
    localparam int HP_BIAS    = 15;

    // Derived exponent-field limits of the single-precision operand
    localparam int REBIAS     = SP_BIAS - HP_BIAS;                  // 112
    localparam int OVF_LIMIT  = SP_BIAS + HP_BIAS + 1;              // 143
    localparam int UNF_LIMIT  = SP_BIAS - HP_BIAS - HP_FRAC_W;      // 102
    localparam int SUB_LIMIT  = REBIAS + 1;                         // 113
    localparam int DROP_W     = SP_FRAC_W - HP_FRAC_W;              // 13
    localparam int ALIGN_W    = SP_FRAC_W + HP_FRAC_W + 1;          // 34
    localparam int SHIFT_W    = $clog2(DROP_W);

    localparam logic [HP_EXP_W-1:0]  HP_EXP_ONES = '1;
    localparam logic [HP_W-2:0]      HP_MAX_MAG  = {{(HP_EXP_W-1){1'b1}}, 1'b0, {HP_FRAC_W{1'b1}}};
    localparam logic [HP_W-2:0]      HP_INF_MAG  = {HP_EXP_ONES, {HP_FRAC_W{1'b0}}};

    typedef enum logic [1:0] {
        RND_NEAR_EVEN = 2'd0,
        RND_ZERO      = 2'd1,
        RND_UP        = 2'd2,
        RND_DOWN      = 2'd3
    } rnd_mode_e;

    // Stage-one result: either a finished word or an aligned mantissa to round
    typedef struct packed {
        logic                 bypass;
        logic [HP_W-1:0]      fixed_word;
        logic                 fixed_inexact;
        logic                 sign;
        logic [HP_EXP_W-1:0]  exp;
        logic [HP_FRAC_W-1:0] mant;
        logic                 guard;
        logic                 sticky;
        rnd_mode_e            mode;
    } align_t;

    function automatic logic [HP_W-1:0] ovf_word(rnd_mode_e m, logic s);
        case (m)
            RND_ZERO: return {s, HP_MAX_MAG};
            RND_UP:   return s ? {1'b1, HP_MAX_MAG} : {1'b0, HP_INF_MAG};
            RND_DOWN: return s ? {1'b1, HP_INF_MAG} : {1'b0, HP_MAX_MAG};
            default:  return {s, HP_INF_MAG};
        endcase
    endfunction

    function automatic logic [HP_W-1:0] unf_word(rnd_mode_e m, logic s);
        if (m == RND_UP && !s)        return {1'b0, {(HP_W-2){1'b0}}, 1'b1};
        else if (m == RND_DOWN && s)  return {1'b1, {(HP_W-2){1'b0}}, 1'b1};
        else                          return {s, {(HP_W-1){1'b0}}};
    endfunction

    function automatic logic rnd_incr(rnd_mode_e m, logic s, logic lsb, logic g, logic st);
        case (m)
            RND_NEAR_EVEN: return g && (st || lsb);
            RND_UP:        return !s && (g || st);
            RND_DOWN:      return s && (g || st);
            default:       return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/f2h_align.sv
module f2h_align
    import f2h_pkg::*;
(
    input  logic [SP_W-1:0] operand,
    input  rnd_mode_e       mode,
    output align_t          info
);

    logic                  sgn;
    logic [SP_EXP_W-1:0]   efld;
    logic [SP_FRAC_W-1:0]  frac;
    logic                  is_sub;
    logic [SHIFT_W-1:0]    k;
    logic [ALIGN_W:0]      src;
    logic [ALIGN_W-1:0]    wide;

    assign sgn  = operand[SP_W-1];
    assign efld = operand[SP_W-2 -: SP_EXP_W];
    assign frac = operand[SP_FRAC_W-1:0];

    // Subnormal results restore the hidden one and shift further right
    assign is_sub = (efld < SP_EXP_W'(SUB_LIMIT));
    assign k      = is_sub ? SHIFT_W'(SP_EXP_W'(SUB_LIMIT) - efld) : '0;
    assign src    = {is_sub, frac, {(HP_FRAC_W+1){1'b0}}};
    assign wide   = ALIGN_W'(src >> k);

    always_comb begin
        info               = '0;
        info.sign          = sgn;
        info.mode          = mode;
        info.mant          = wide[ALIGN_W-1 -: HP_FRAC_W];
        info.guard         = wide[ALIGN_W-HP_FRAC_W-1];
        info.sticky        = |wide[ALIGN_W-HP_FRAC_W-2:0];
        info.exp           = is_sub ? '0 : HP_EXP_W'(efld - SP_EXP_W'(REBIAS));
        if (efld == '1) begin
            info.bypass     = 1'b1;
            info.fixed_word = (frac != '0)
                ? {sgn, HP_EXP_ONES, 1'b1, frac[SP_FRAC_W-2 -: HP_FRAC_W-1]}
                : {sgn, HP_INF_MAG};
        end else if (efld == '0 && frac == '0) begin
            info.bypass     = 1'b1;
            info.fixed_word = {sgn, {(HP_W-1){1'b0}}};
        end else if (efld >= SP_EXP_W'(OVF_LIMIT)) begin
            info.bypass        = 1'b1;
            info.fixed_word    = ovf_word(mode, sgn);
            info.fixed_inexact = 1'b1;
        end else if (efld < SP_EXP_W'(UNF_LIMIT)) begin
            info.bypass        = 1'b1;
            info.fixed_word    = unf_word(mode, sgn);
            info.fixed_inexact = 1'b1;
        end
    end

endmodule

// File: rtl/f2h_round.sv
module f2h_round
    import f2h_pkg::*;
(
    input  align_t          info,
    output logic [HP_W-1:0] word,
    output logic            inexact
);

    logic                 up;
    logic [HP_FRAC_W:0]   sum;
    logic [HP_EXP_W-1:0]  exp_n;
    logic [HP_FRAC_W-1:0] mant_n;

    assign up  = rnd_incr(info.mode, info.sign, info.mant[0], info.guard, info.sticky);
    assign sum = {1'b0, info.mant} + (HP_FRAC_W+1)'(up);

    // A carry out of the fraction moves into the exponent field
    always_comb begin
        if (sum[HP_FRAC_W]) begin
            exp_n  = info.exp + HP_EXP_W'(1);
            mant_n = '0;
        end else begin
            exp_n  = info.exp;
            mant_n = sum[HP_FRAC_W-1:0];
        end
    end

    always_comb begin
        if (info.bypass) begin
            word    = info.fixed_word;
            inexact = info.fixed_inexact;
        end else begin
            word    = {info.sign, exp_n, mant_n};
            inexact = info.guard | info.sticky;
        end
    end

endmodule

// File: rtl/f32_to_f16_conv.sv
module f32_to_f16_conv
    import f2h_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic [31:0] in_operand,
    input  logic [1:0]  in_mode,
    output logic        out_valid,
    output logic [15:0] out_result,
    output logic        out_inexact
);

    align_t          s1_d;
    align_t          s1_q;
    logic            s1_v;
    logic [HP_W-1:0] rnd_word;
    logic            rnd_inexact;

    f2h_align u_align (
        .operand (in_operand),
        .mode    (rnd_mode_e'(in_mode)),
        .info    (s1_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_v <= 1'b0;
        end else begin
            s1_v <= in_valid;
        end
        if (in_valid) begin
            s1_q <= s1_d;
        end
    end

    f2h_round u_round (
        .info    (s1_q),
        .word    (rnd_word),
        .inexact (rnd_inexact)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
        end else begin
            out_valid <= s1_v;
        end
        if (s1_v) begin
            out_result  <= rnd_word;
            out_inexact <= rnd_inexact;
        end
    end

    // R1: each stage forwards the strobe of the stage before it one edge later
    assert_stage1_valid_R1: assert property (@(posedge clk) disable iff (rst)
        $past(!rst) |-> (s1_v == $past(in_valid)));

    assert_out_valid_R1: assert property (@(posedge clk) disable iff (rst)
        $past(!rst) |-> (out_valid == $past(s1_v)));

    // R2: any NaN leaving the block is quiet and exact
    assert_nan_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_result[14:10] == 5'h1F && out_result[9:0] != '0)
        |-> (out_result[9] && !out_inexact));

    // R11: a rounding-path operand with nothing discarded leaves unchanged
    assert_exact_passthru_R11: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(s1_v && !s1_q.bypass && !s1_q.guard && !s1_q.sticky))
        |-> (!out_inexact && out_result == $past({s1_q.sign, s1_q.exp, s1_q.mant})));

    // R9: toward-zero never increments the kept fraction
    assert_rtz_truncates_R9: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(s1_v && !s1_q.bypass && s1_q.mode == RND_ZERO))
        |-> (out_result == $past({s1_q.sign, s1_q.exp, s1_q.mant})));

endmodule

// File: tb/f32_to_f16_conv_tb.sv
module f32_to_f16_conv_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] in_operand = '0;
    logic [1:0]  in_mode = '0;
    logic        out_valid;
    logic [15:0] out_result;
    logic        out_inexact;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    f32_to_f16_conv u_dut (
        .clk         (clk),
        .rst         (rst),
        .in_valid    (in_valid),
        .in_operand  (in_operand),
        .in_mode     (in_mode),
        .out_valid   (out_valid),
        .out_result  (out_result),
        .out_inexact (out_inexact)
    );

    // {operand, mode, expected result, expected inexact, requirement number}
    localparam int NV = 42;
    localparam logic [54:0] VEC [NV] = '{
        {32'h3F800000, 2'd0, 16'h3C00, 1'b0, 4'd6},   // R6 one
        {32'hC0000000, 2'd0, 16'hC000, 1'b0, 4'd6},   // R6 minus two
        {32'h3FC00000, 2'd0, 16'h3E00, 1'b0, 4'd6},   // R6 one and a half
        {32'h38800000, 2'd0, 16'h0400, 1'b0, 4'd6},   // R6 smallest normal
        {32'h477FE000, 2'd1, 16'h7BFF, 1'b0, 4'd6},   // R6 largest finite
        {32'h7F800001, 2'd0, 16'h7E00, 1'b0, 4'd2},   // R2 signalling NaN
        {32'hFFAAA000, 2'd2, 16'hFF55, 1'b0, 4'd2},   // R2 negative NaN payload
        {32'h7F800000, 2'd1, 16'h7C00, 1'b0, 4'd3},   // R3 +inf
        {32'hFF800000, 2'd0, 16'hFC00, 1'b0, 4'd3},   // R3 -inf
        {32'h80000000, 2'd2, 16'h8000, 1'b0, 4'd3},   // R3 -0
        {32'h00000000, 2'd3, 16'h0000, 1'b0, 4'd3},   // R3 +0
        {32'h47800000, 2'd0, 16'h7C00, 1'b1, 4'd4},   // R4
        {32'h47800000, 2'd1, 16'h7BFF, 1'b1, 4'd4},   // R4
        {32'h47800000, 2'd2, 16'h7C00, 1'b1, 4'd4},   // R4
        {32'h47800000, 2'd3, 16'h7BFF, 1'b1, 4'd4},   // R4
        {32'hC7800000, 2'd0, 16'hFC00, 1'b1, 4'd4},   // R4
        {32'hC7800000, 2'd1, 16'hFBFF, 1'b1, 4'd4},   // R4
        {32'hC7800000, 2'd2, 16'hFBFF, 1'b1, 4'd4},   // R4
        {32'hC7800000, 2'd3, 16'hFC00, 1'b1, 4'd4},   // R4
        {32'h32800000, 2'd0, 16'h0000, 1'b1, 4'd5},   // R5
        {32'h32800000, 2'd2, 16'h0001, 1'b1, 4'd5},   // R5
        {32'h32800000, 2'd3, 16'h0000, 1'b1, 4'd5},   // R5
        {32'hB2800000, 2'd3, 16'h8001, 1'b1, 4'd5},   // R5
        {32'hB2800000, 2'd2, 16'h8000, 1'b1, 4'd5},   // R5
        {32'h00000001, 2'd2, 16'h0001, 1'b1, 4'd5},   // R5 input subnormal
        {32'h80000001, 2'd0, 16'h8000, 1'b1, 4'd5},   // R5 input subnormal
        {32'h33800000, 2'd0, 16'h0001, 1'b0, 4'd7},   // R7 smallest subnormal
        {32'h38000000, 2'd0, 16'h0200, 1'b0, 4'd7},   // R7 shift of 14
        {32'h33000000, 2'd0, 16'h0000, 1'b1, 4'd7},   // R7 shift of 24, tie to even
        {32'h33000000, 2'd2, 16'h0001, 1'b1, 4'd7},   // R7 shift of 24, up
        {32'h3F801000, 2'd0, 16'h3C00, 1'b1, 4'd8},   // R8 tie, even kept
        {32'h3F803000, 2'd0, 16'h3C02, 1'b1, 4'd8},   // R8 tie, odd bumped
        {32'h3F801001, 2'd0, 16'h3C01, 1'b1, 4'd8},   // R8 above half
        {32'h3F800001, 2'd2, 16'h3C01, 1'b1, 4'd9},   // R9
        {32'h3F800001, 2'd1, 16'h3C00, 1'b1, 4'd9},   // R9
        {32'h3F800001, 2'd3, 16'h3C00, 1'b1, 4'd9},   // R9
        {32'hBF800001, 2'd3, 16'hBC01, 1'b1, 4'd9},   // R9
        {32'hBF800001, 2'd2, 16'hBC00, 1'b1, 4'd9},   // R9
        {32'h477FF000, 2'd0, 16'h7C00, 1'b1, 4'd10},  // R10 max finite to inf
        {32'h387FFFFF, 2'd0, 16'h0400, 1'b1, 4'd10},  // R10 subnormal to normal
        {32'h3FFFF000, 2'd0, 16'h4000, 1'b1, 4'd10},  // R10 exponent step
        {32'h3F800001, 2'd0, 16'h3C00, 1'b1, 4'd11}   // R11 below half
    };

    task automatic check(input bit ok, input int req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL R%0d %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic [54:0] v);
        in_valid   = 1'b1;
        in_operand = v[54:23];
        in_mode    = v[22:21];
    endtask

    task automatic expect_vec(input logic [54:0] v);
        logic [16:0] act;
        act = {out_result, out_inexact};
        check(out_valid == 1'b1, int'(v[3:0]), "strobe", 32'(out_valid), 32'd1);
        check(act == v[20:4], int'(v[3:0]), $sformatf("op %h mode %0d", v[54:23], v[22:21]),
              32'(act), 32'(v[20:4]));
    endtask

    initial begin
        #(20 * 150000);
        checks++;
        failures++;
        $display("FAIL R1 watchdog expired actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, 1, "valid during reset", 32'(out_valid), 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0, 1, "valid after reset", 32'(out_valid), 32'd0);

        // Table walk: one operation at a time, result read two edges later
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(VEC[i]);
            @(negedge clk);
            in_valid = 1'b0;
            @(negedge clk);
            expect_vec(VEC[i]);
        end

        // R1: strobe drops one cycle after a lone result
        @(negedge clk);
        check(out_valid == 1'b0, 1, "idle after single op", 32'(out_valid), 32'd0);

        // R1: back-to-back stream with mixed modes
        drive(VEC[11]);
        @(negedge clk);
        drive(VEC[31]);
        @(negedge clk);
        expect_vec(VEC[11]);
        drive(VEC[33]);
        @(negedge clk);
        expect_vec(VEC[31]);
        in_valid = 1'b0;
        @(negedge clk);
        expect_vec(VEC[33]);
        @(negedge clk);
        check(out_valid == 1'b0, 1, "idle after stream", 32'(out_valid), 32'd0);

        // R1: reset flushes an operation still in flight
        drive(VEC[0]);
        @(negedge clk);
        in_valid = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0, 1, "flushed by reset", 32'(out_valid), 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0, 1, "no late result", 32'(out_valid), 32'd0);
        @(negedge clk);
        check(out_valid == 1'b0, 1, "still idle", 32'(out_valid), 32'd0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule